// File: doc/BRIEF.md
# Dual-Bank Vectored Interrupt Controller

This block gathers 64 interrupt sources and drives two processor request lines, a normal request (`irq_o`) and a fast request (`fiq_o`). Software programs it through a simple word-wide register bus. Writes are single-cycle strobes, and reads are combinational from the address.

The sources are split into two banks of 32. Source n lives in bank n[5], at bit n[4:0]. Every per-source register has a bank-0 word and a bank-1 word 4 bytes above it.

For each source, software sets:
- whether it is level or edge detected;
- which level or edge counts as active;
- whether it is routed to the fast or the normal line;
- whether it is enabled.

Edge sources keep a latch that software acknowledges. Software can also force any source active. A pending-number readout returns the lowest-numbered enabled source that is active on the normal line.

External sources are first synchronised through two flops. A third flop gives the previous sample for edge detection. A level change therefore shows in raw status after two clock edges, and an edge is latched on the third.

Top module: `dual_bank_vic`

## Requirements
- R1: After reset:
  - every register reads 0;
  - the pending number at 0xD0 reads 64;
  - `irq_o` and `fiq_o` are low.
- R2: Source n is bit n[4:0] of the bank-0 word (offset +0) when n<32, and of the bank-1 word (offset +4) when n≥32. This holds for every per-source register.
- R3: The enable word has three write addresses:
  - 0x10/0x14 load it directly;
  - 0x20/0x24 clear each bit written as 1;
  - 0x30/0x34 set each bit written as 1.
  Zero bits written to the clear or set address change nothing.
- R4: The route word at 0x00/0x04 sends a source to the fast line when its bit is 1 and to the normal line when its bit is 0.
- R5: Type bit (0x40/0x44) = 0 selects level mode. In level mode a source is active while its synchronised input is high (polarity bit at 0x50/0x54 = 0) or low (polarity bit = 1), with no memory.
- R6: Type bit = 1 selects edge mode. A rising edge (polarity 0) or a falling edge (polarity 1) sets a latch that holds after the input returns. Writing 1 to that source's bit at 0xB0/0xB4 clears the latch.
- R7: Status words:
  - 0xA0/0xA4 return raw active state, regardless of enable;
  - 0x80/0x84 return raw & enable & normal-routed;
  - 0x90/0x94 return raw & enable & fast-routed.
- R8: Bits set in the software word at 0xC0/0xC4 make the matching sources active in raw status.
- R9: Master word at 0x64:
  - bit 0 gates `irq_o`, bit 1 gates `fiq_o`;
  - each output is high when its gate is set and its status has any bit set;
  - the status words are not gated.
- R10: 0xD0 returns the lowest source number whose bit is set in normal-line status, or 64 when none is set.
- R11: Writes to read-only addresses (status words and 0xD0) and to addresses with nonzero low two bits change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 8 | Byte address of the register word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| src_in | input | 64 | Asynchronous interrupt source inputs |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
Most of the internal state is visible directly as a status word or an output line.
- A wrong edge latch shows in raw status and on the request lines one cycle after the missed or spurious edge. It then stays visible until acknowledged, so a dropped clear cannot hide.
- An enable, route or master bit corrupted by a mis-decoded write changes the masked status words and `irq_o`/`fiq_o` combinationally, in the very next cycle.
- A priority error in the pending-number logic only appears when two or more sources are pending together. The tests therefore stack sources on both sides of the bank boundary.

// File: rtl/dual_bank_vic.sv
module dual_bank_vic #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [2*DATA_W-1:0] src_in,
  output logic              irq_o,
  output logic              fiq_o
);
  localparam int NSRC = 2 * DATA_W;
  localparam int PW   = $clog2(NSRC) + 1;
  localparam logic [PW-1:0] NONE = PW'(NSRC);

  localparam logic [ADDR_W-1:0] A_ROUTE = ADDR_W'('h00);
  localparam logic [ADDR_W-1:0] A_EN    = ADDR_W'('h10);
  localparam logic [ADDR_W-1:0] A_ENCLR = ADDR_W'('h20);
  localparam logic [ADDR_W-1:0] A_ENSET = ADDR_W'('h30);
  localparam logic [ADDR_W-1:0] A_TYPE  = ADDR_W'('h40);
  localparam logic [ADDR_W-1:0] A_POL   = ADDR_W'('h50);
  localparam logic [ADDR_W-1:0] A_MST   = ADDR_W'('h64);
  localparam logic [ADDR_W-1:0] A_ISTAT = ADDR_W'('h80);
  localparam logic [ADDR_W-1:0] A_FSTAT = ADDR_W'('h90);
  localparam logic [ADDR_W-1:0] A_RAW   = ADDR_W'('hA0);
  localparam logic [ADDR_W-1:0] A_ACK   = ADDR_W'('hB0);
  localparam logic [ADDR_W-1:0] A_SOFT  = ADDR_W'('hC0);
  localparam logic [ADDR_W-1:0] A_PEND  = ADDR_W'('hD0);

  logic [NSRC-1:0] route_q, en_q, type_q, pol_q, lat_q, soft_q;
  logic [NSRC-1:0] s1_q, s2_q, s3_q;
  logic [1:0]      mst_q;
  logic [PW-1:0]   pend;

  wire wr_ok = bus_wr && (bus_addr[1:0] == 2'b00);
  wire [ADDR_W-1:0] base = {bus_addr[ADDR_W-1:3], 3'b000};
  wire hi = bus_addr[2];
  wire [NSRC-1:0] lane = hi ? {{DATA_W{1'b1}}, {DATA_W{1'b0}}} : {{DATA_W{1'b0}}, {DATA_W{1'b1}}};
  wire [NSRC-1:0] wv   = hi ? {bus_wdata, {DATA_W{1'b0}}} : {{DATA_W{1'b0}}, bus_wdata};

  wire [NSRC-1:0] lvl   = s2_q ^ pol_q;
  wire [NSRC-1:0] evt   = type_q & (s2_q ^ s3_q) & lvl;
  wire [NSRC-1:0] raw   = (type_q & lat_q) | (~type_q & lvl) | soft_q;
  wire [NSRC-1:0] istat = raw & en_q & ~route_q;
  wire [NSRC-1:0] fstat = raw & en_q & route_q;

  assign irq_o = mst_q[0] & (|istat);
  assign fiq_o = mst_q[1] & (|fstat);

  function automatic logic [NSRC-1:0] load(input logic [NSRC-1:0] cur,
                                           input logic [NSRC-1:0] m,
                                           input logic [NSRC-1:0] v);
    return (cur & ~m) | v;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      s1_q <= src_in;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      route_q <= '0;
      en_q    <= '0;
      type_q  <= '0;
      pol_q   <= '0;
      soft_q  <= '0;
      mst_q   <= '0;
    end else if (wr_ok) begin
      case (base)
        A_ROUTE: route_q <= load(route_q, lane, wv);
        A_EN:    en_q    <= load(en_q, lane, wv);
        A_ENCLR: en_q    <= en_q & ~wv;
        A_ENSET: en_q    <= en_q | wv;
        A_TYPE:  type_q  <= load(type_q, lane, wv);
        A_POL:   pol_q   <= load(pol_q, lane, wv);
        A_SOFT:  soft_q  <= load(soft_q, lane, wv);
        default: ;
      endcase
      if (bus_addr == A_MST) mst_q <= bus_wdata[1:0];
    end
  end

  wire [NSRC-1:0] ack = (wr_ok && base == A_ACK) ? wv : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lat_q <= '0;
    else        lat_q <= (lat_q & ~ack) | evt;
  end

  always_comb begin
    pend = NONE;
    for (int i = NSRC - 1; i >= 0; i--)
      if (istat[i]) pend = PW'(i);
  end

  function automatic logic [DATA_W-1:0] pick(input logic [NSRC-1:0] v, input logic h);
    return h ? v[NSRC-1:DATA_W] : v[DATA_W-1:0];
  endfunction

  always_comb begin
    bus_rdata = '0;
    if (bus_addr[1:0] == 2'b00) begin
      if (bus_addr == A_MST)       bus_rdata = DATA_W'(mst_q);
      else if (bus_addr == A_PEND) bus_rdata = DATA_W'(pend);
      else begin
        case (base)
          A_ROUTE: bus_rdata = pick(route_q, hi);
          A_EN:    bus_rdata = pick(en_q, hi);
          A_TYPE:  bus_rdata = pick(type_q, hi);
          A_POL:   bus_rdata = pick(pol_q, hi);
          A_ISTAT: bus_rdata = pick(istat, hi);
          A_FSTAT: bus_rdata = pick(fstat, hi);
          A_RAW:   bus_rdata = pick(raw, hi);
          A_SOFT:  bus_rdata = pick(soft_q, hi);
          default: bus_rdata = '0;
        endcase
      end
    end
  end

  // R3
  enset_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && bus_addr == A_ENSET) |=>
      ((en_q[DATA_W-1:0] & $past(bus_wdata)) == $past(bus_wdata)));

  // R3
  enclr_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && bus_addr == A_ENCLR) |=> ((en_q[DATA_W-1:0] & $past(bus_wdata)) == '0));

  // R9
  irq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> mst_q[0]);

  // R9
  fiq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_o |-> mst_q[1]);

  // R10
  pend_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend != NONE) |-> istat[pend[PW-2:0]]);

  // R10
  pend_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (istat == '0) |-> (pend == NONE));

  // R6
  ack_only_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_q[0] && !ack[0]) |=> lat_q[0]);
endmodule

// File: tb/dual_bank_vic_bench.sv
module dual_bank_vic_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [63:0] src = '0;
  logic        irq_o, fiq_o;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dual_bank_vic u_dual_bank_vic (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_in(src),
    .irq_o(irq_o), .fiq_o(fiq_o)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    bus_addr = a;
    #1;
    check(tag, bus_rdata, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clean();
    wr(8'h10, 0); wr(8'h14, 0); wr(8'hC0, 0); wr(8'hC4, 0);
    wr(8'h00, 0); wr(8'h04, 0); wr(8'h40, 0); wr(8'h44, 0);
    wr(8'h50, 0); wr(8'h54, 0); wr(8'h64, 0);
    wr(8'hB0, 32'hFFFF_FFFF); wr(8'hB4, 32'hFFFF_FFFF);
  endtask

  task automatic t_reset();
    rd_chk("R1 route0", 8'h00, 0);
    rd_chk("R1 en1", 8'h14, 0);
    rd_chk("R1 type0", 8'h40, 0);
    rd_chk("R1 pol1", 8'h54, 0);
    rd_chk("R1 master", 8'h64, 0);
    rd_chk("R1 raw0", 8'hA0, 0);
    rd_chk("R1 soft1", 8'hC4, 0);
    rd_chk("R1 pend", 8'hD0, 64);
    check("R1 irq", {31'b0, irq_o}, 0);
    check("R1 fiq", {31'b0, fiq_o}, 0);
  endtask

  task automatic t_enable();
    wr(8'h30, 32'h0000_00F0);
    wr(8'h34, 32'h8000_0001);
    rd_chk("R3 set bank0", 8'h10, 32'h0000_00F0);
    rd_chk("R2 set bank1", 8'h14, 32'h8000_0001);
    wr(8'h20, 32'h0000_0030);
    rd_chk("R3 clear", 8'h10, 32'h0000_00C0);
    wr(8'h24, 32'h0);
    rd_chk("R3 clear zero no effect", 8'h14, 32'h8000_0001);
    wr(8'h30, 32'h0);
    rd_chk("R3 set zero no effect", 8'h10, 32'h0000_00C0);
    wr(8'h10, 32'h0000_0005);
    rd_chk("R3 direct", 8'h10, 32'h0000_0005);
    rd_chk("R3 direct other bank kept", 8'h14, 32'h8000_0001);
    clean();
  endtask

  task automatic t_level();
    src[3] = 1'b1;
    idle(3);
    rd_chk("R7 raw unmasked", 8'hA0, 32'h8);
    rd_chk("R7 istat disabled", 8'h80, 0);
    wr(8'h30, 32'h8);
    rd_chk("R7 istat enabled", 8'h80, 32'h8);
    check("R9 irq gated off", {31'b0, irq_o}, 0);
    wr(8'h64, 32'h1);
    check("R9 irq on", {31'b0, irq_o}, 1);
    rd_chk("R10 pend 3", 8'hD0, 3);
    wr(8'h50, 32'h8);
    rd_chk("R5 low active, input high", 8'hA0, 0);
    check("R5 irq drops", {31'b0, irq_o}, 0);
    src[3] = 1'b0;
    idle(3);
    rd_chk("R5 low active, input low", 8'hA0, 32'h8);
    wr(8'h50, 32'h0);
    rd_chk("R5 no memory", 8'hA0, 0);
    src[40] = 1'b1;
    idle(3);
    rd_chk("R2 src40 raw bank1", 8'hA4, 32'h100);
    rd_chk("R2 src40 not bank0", 8'hA0, 0);
    wr(8'h34, 32'h100);
    rd_chk("R2 istat bank1", 8'h84, 32'h100);
    rd_chk("R10 pend 40", 8'hD0, 40);
    src[40] = 1'b0;
    idle(3);
    rd_chk("R10 pend none", 8'hD0, 64);
    clean();
  endtask

  task automatic t_edge();
    wr(8'h44, 32'h2000);
    wr(8'h34, 32'h2000);
    wr(8'h64, 32'h1);
    src[45] = 1'b1; idle(4);
    src[45] = 1'b0; idle(4);
    rd_chk("R6 rising latched", 8'hA4, 32'h2000);
    rd_chk("R6 pend 45", 8'hD0, 45);
    check("R6 irq from latch", {31'b0, irq_o}, 1);
    wr(8'hB0, 32'hFFFF_FFFF);
    rd_chk("R6 other bank ack no effect", 8'hA4, 32'h2000);
    wr(8'hB4, 32'h2000);
    rd_chk("R6 ack clears", 8'hA4, 0);
    check("R6 irq after ack", {31'b0, irq_o}, 0);
    wr(8'h54, 32'h2000);
    src[45] = 1'b1; idle(4);
    rd_chk("R6 falling mode ignores rise", 8'hA4, 0);
    src[45] = 1'b0; idle(4);
    rd_chk("R6 falling latched", 8'hA4, 32'h2000);
    clean();
    rd_chk("R6 cleaned", 8'hA4, 0);
  endtask

  task automatic t_route_soft();
    wr(8'hC0, 32'h1);
    rd_chk("R8 soft raw", 8'hA0, 32'h1);
    wr(8'h30, 32'h1);
    rd_chk("R7 soft istat", 8'h80, 32'h1);
    rd_chk("R10 pend 0", 8'hD0, 0);
    wr(8'h00, 32'h1);
    rd_chk("R4 fstat", 8'h90, 32'h1);
    rd_chk("R4 istat empty", 8'h80, 0);
    rd_chk("R10 fast not pending", 8'hD0, 64);
    check("R9 fiq gated off", {31'b0, fiq_o}, 0);
    wr(8'h64, 32'h3);
    check("R4 fiq on", {31'b0, fiq_o}, 1);
    check("R4 irq off", {31'b0, irq_o}, 0);
    wr(8'h64, 32'h1);
    check("R9 fiq gate bit1", {31'b0, fiq_o}, 0);
    clean();
    wr(8'hC4, 32'h1);
    wr(8'hC0, 32'h8000_0000);
    wr(8'h34, 32'h1);
    wr(8'h30, 32'h8000_0000);
    rd_chk("R10 lowest across banks", 8'hD0, 31);
    wr(8'h20, 32'h8000_0000);
    rd_chk("R10 next lowest", 8'hD0, 32);
    clean();
  endtask

  task automatic t_readonly();
    wr(8'hA0, 32'hFFFF_FFFF);
    wr(8'h80, 32'hFFFF_FFFF);
    wr(8'hD0, 32'hFFFF_FFFF);
    wr(8'h31, 32'hFFFF_FFFF);
    wr(8'hC2, 32'hFFFF_FFFF);
    rd_chk("R11 en untouched", 8'h10, 0);
    rd_chk("R11 soft untouched", 8'hC0, 0);
    rd_chk("R11 raw untouched", 8'hA0, 0);
    rd_chk("R11 pend", 8'hD0, 64);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(2);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_enable();
    t_level();
    t_edge();
    t_route_soft();
    t_readonly();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule